// File: doc/BRIEF.md
# Rate-Throttled Pseudo-Random Word Source

This block feeds a link MAC with 64-bit pseudo-random words for a built-in self test of a serial link. The words come from a 31-bit maximal-length shift register, so a checker at the far end of the link can synchronise to the stream and count bit errors. The word rate is set at run time by a 6-bit rate value, which gives a fractional duty cycle of (rate+1)/64 words per clock. Rate 63 therefore gives one word every clock.

The output is a valid/data pair with a downstream ready. A stalled word holds its value until it is taken. A separate enable starts and stops the source, so the receive side can keep draining after generation stops. When enable rises, the first word that leaves carries a one-cycle start marker. Round-trip latency can be timed from that marker.

Top module: `prbs_rate_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `valid` and `start` are 0 and `data` is all zeros.
- R2: With `enable` and `ready` held high for 64 clocks starting from a disabled state, and `rate` fixed at r, exactly r+1 words are presented. At r=63 a word is presented on every one of those clocks.
- R3: Word issue is paced by a 6-bit accumulator. The accumulator is cleared while `enable` is low. On every enabled clock it adds rate+1, and an issue opportunity arises on each clock where the sum reaches or passes 64 (the carry out). The sum then wraps modulo 64.
- R4: `data` follows the sequence x^31+x^28+1. The state is s[30:0], seeded to 31'h2AAAAAAB at reset. One step computes b = s[30]^s[27], emits b and shifts to {s[29:0], b}. A word is 64 steps, with the first emitted bit in data[63]. The state advances only when a word is issued.
- R5: While `valid` is high and `ready` is low, `valid` stays high and `data` does not change.
- R6: Opportunities that arise while a word is stalled are kept, at most one of them. The kept opportunity issues a word on the first clock on which the output is free.
- R7: `start` is high for exactly one cycle, in the cycle in which the first word issued after a rising edge of `enable` first appears on `valid`.
- R8: From the first clock on which `enable` is low, no new word is issued and any kept opportunity is dropped. A word already presented stays valid until it is accepted.
- R9: After a word is accepted (`valid` and `ready` high at a clock), `valid` is low in the next cycle unless a new word was issued at that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Generator run enable |
| rate | input | 6 | Throughput setting, (rate+1)/64 words per clock |
| ready | input | 1 | Downstream accepts the presented word |
| data | output | 64 | Pseudo-random word |
| valid | output | 1 | `data` holds a word to be taken |
| start | output | 1 | One-cycle marker on the first word after enable rises |

## Verification
Fixed-rate windows at rates 0, 5, 31 and 63, each started from a disabled state with ready held high, separate an accumulator that paces correctly from one that is off by one or never clears. A long stall at rate 31, followed by release, tells a one-deep store of missed opportunities from a deeper one or from none. Long random runs change the rate, toggle the enable mid-stall and hold ready low about a third of the time. They are compared cycle by cycle against a model built from the requirements. Those runs expose errors in the word sequence, in the hold on a stall, in where the start marker falls and in the drain after disable.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;
  localparam int WORD_W = 64;
  localparam int RATE_W = 6;
  localparam int LFSR_W = 31;
  localparam int TAP_HI = 31;
  localparam int TAP_LO = 28;
  localparam logic [LFSR_W-1:0] SEED = 31'h2AAAAAAB;
endpackage

// File: rtl/prbs_rate_accum.sv
module prbs_rate_accum #(
  parameter int RATE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int SUM_W = RATE_W + 1;

  logic [RATE_W-1:0] acc_q, acc_n;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, rate} + SUM_W'(1);
    tick  = run & sum[RATE_W];
    acc_n = run ? sum[RATE_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_n;
  end
endmodule

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
  parameter int              WORD_W = 64,
  parameter int              LFSR_W = 31,
  parameter int              TAP_HI = 31,
  parameter int              TAP_LO = 28,
  parameter logic [LFSR_W-1:0] SEED = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [WORD_W-1:0] word
);
  logic [LFSR_W-1:0] state_q, state_n, walk;
  logic [WORD_W-1:0] bits;
  logic              fb;

  always_comb begin
    walk = state_q;
    bits = '0;
    fb   = 1'b0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb      = walk[TAP_HI-1] ^ walk[TAP_LO-1];
      bits[i] = fb;
      walk    = {walk[LFSR_W-2:0], fb};
    end
    word    = bits;
    state_n = advance ? walk : state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_n;
  end
endmodule

// File: rtl/prbs_issue_ctrl.sv
module prbs_issue_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  input  logic ready,
  output logic load,
  output logic valid,
  output logic start
);
  logic valid_q, valid_n;
  logic pend_q, pend_n;
  logic armed_q, armed_n;
  logic en_prev_q;
  logic start_q, start_n;
  logic rise, have_slot;

  always_comb begin
    rise      = enable & ~en_prev_q;
    have_slot = tick | pend_q;
    load      = enable & have_slot & (~valid_q | ready);

    if (!enable)              pend_n = 1'b0;
    else if (tick && pend_q)  pend_n = 1'b1;
    else                      pend_n = have_slot & ~load;

    start_n = load & (armed_q | rise);
    armed_n = enable & (armed_q | rise) & ~load;

    if (load)                  valid_n = 1'b1;
    else if (valid_q && ready) valid_n = 1'b0;
    else                       valid_n = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      pend_q    <= 1'b0;
      armed_q   <= 1'b0;
      en_prev_q <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      valid_q   <= valid_n;
      pend_q    <= pend_n;
      armed_q   <= armed_n;
      en_prev_q <= enable;
      start_q   <= start_n;
    end
  end

  assign valid = valid_q;
  assign start = start_q;
endmodule

// File: rtl/prbs_rate_gen.sv
module prbs_rate_gen #(
  parameter int WORD_W = prbs_gen_pkg::WORD_W,
  parameter int RATE_W = prbs_gen_pkg::RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [RATE_W-1:0] rate,
  input  logic              ready,
  output logic [WORD_W-1:0] data,
  output logic              valid,
  output logic              start
);
  logic              tick, load;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] data_q;

  prbs_rate_accum #(.RATE_W(RATE_W)) u_accum (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (enable),
    .rate (rate),
    .tick (tick)
  );

  prbs_lfsr #(
    .WORD_W(WORD_W),
    .LFSR_W(prbs_gen_pkg::LFSR_W),
    .TAP_HI(prbs_gen_pkg::TAP_HI),
    .TAP_LO(prbs_gen_pkg::TAP_LO),
    .SEED  (prbs_gen_pkg::SEED)
  ) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(load),
    .word   (word)
  );

  prbs_issue_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(enable),
    .tick  (tick),
    .ready (ready),
    .load  (load),
    .valid (valid),
    .start (start)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= word;
  end

  assign data = data_q;
endmodule

// File: rtl/prbs_rate_gen_chk.sv
module prbs_rate_gen_chk #(
  parameter int WORD_W = 64,
  parameter int RATE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [RATE_W-1:0] rate,
  input logic              ready,
  input logic [WORD_W-1:0] data,
  input logic              valid,
  input logic              start
);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));

  // R7
  start_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> valid);

  // R7
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  // R8
  disable_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !(valid && !ready)) |=> !valid);

  // R2
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (rate == {RATE_W{1'b1}}) && (ready || !valid)) |=> valid);
endmodule

bind prbs_rate_gen prbs_rate_gen_chk #(.WORD_W(WORD_W), .RATE_W(RATE_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .enable(enable),
  .rate  (rate),
  .ready (ready),
  .data  (data),
  .valid (valid),
  .start (start)
);

// File: tb/sim_prbs_rate_gen.sv
module sim_prbs_rate_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [5:0]  rate = '0;
  logic        ready = 1'b0;
  logic [63:0] data;
  logic        valid;
  logic        start;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // model state
  int          m_acc;
  bit          m_pend, m_valid, m_enp, m_arm, m_start;
  logic [63:0] m_data;
  logic [30:0] m_lfsr;

  prbs_rate_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate(rate), .ready(ready),
    .data(data), .valid(valid), .start(start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_pend = 0; m_valid = 0; m_enp = 0; m_arm = 0; m_start = 0;
    m_data = '0; m_lfsr = 31'h2AAAAAAB;
  endtask

  // Next word from the R4 definition
  task automatic gen_word();
    logic b;
    for (int i = 63; i >= 0; i--) begin
      b = m_lfsr[30] ^ m_lfsr[27];
      m_data[i] = b;
      m_lfsr = {m_lfsr[29:0], b};
    end
  endtask

  task automatic model_step(bit e, int r, bit rd);
    bit tick, rise, ld, np;
    tick = 0;
    if (e) begin
      m_acc += r + 1;
      if (m_acc >= 64) begin tick = 1; m_acc -= 64; end
    end else m_acc = 0;
    rise = e && !m_enp;
    ld = e && (tick || m_pend) && (!m_valid || rd);
    if (!e) np = 0;
    else if (tick && m_pend) np = 1;
    else np = (tick || m_pend) && !ld;
    m_start = ld && (m_arm || rise);
    m_arm = e && (m_arm || rise) && !ld;
    if (ld) begin m_valid = 1; gen_word(); end
    else if (m_valid && rd) m_valid = 0;
    m_pend = np;
    m_enp = e;
  endtask

  task automatic cyc(bit e, int r, bit rd);
    enable = e; rate = 6'(r); ready = rd;
    model_step(e, r, rd);
    @(negedge clk);
    cycles++;
    check("R3 R5 R6 R8 R9 valid", {63'd0, valid}, {63'd0, m_valid});
    check("R7 start", {63'd0, start}, {63'd0, m_start});
    if (m_valid) check("R4 data", data, m_data);
  endtask

  task automatic rate_window(int r);
    int cnt;
    for (int i = 0; i < 3; i++) cyc(0, r, 1);
    cnt = 0;
    for (int i = 0; i < 64; i++) begin
      cyc(1, r, 1);
      if (valid) cnt++;
    end
    check("R2 words per 64 clocks", 64'(cnt), 64'(r + 1));
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", wd);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int r;
    bit e;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {63'd0, valid}, 64'd0);
    check("R1 start in reset", {63'd0, start}, 64'd0);
    check("R1 data in reset", data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {63'd0, valid}, 64'd0);
    check("R1 data after reset", data, 64'd0);

    // R2 directed windows
    rate_window(63);
    rate_window(0);
    rate_window(31);
    rate_window(5);

    // R6 stall at rate 31, then release
    for (int i = 0; i < 3; i++) cyc(0, 31, 1);
    for (int i = 0; i < 4; i++) cyc(1, 31, 1);
    for (int i = 0; i < 9; i++) cyc(1, 31, 0);
    for (int i = 0; i < 8; i++) cyc(1, 31, 1);

    // R8 disable during a stall, then drain
    for (int i = 0; i < 4; i++) cyc(1, 63, 0);
    for (int i = 0; i < 3; i++) cyc(0, 63, 0);
    for (int i = 0; i < 3; i++) cyc(0, 63, 1);

    // random traffic
    r = 20; e = 1;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 49) == 0) r = $urandom_range(0, 63);
      if ($urandom_range(0, 79) == 0) e = !e;
      cyc(e, r, $urandom_range(0, 9) < 7);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule